// File: doc/BRIEF.md
# Feedback Echo Processor

This block adds a decaying echo to a stream of signed 16-bit audio samples. A circular delay line in on-chip RAM holds the most recent DEPTH results. When a new sample arrives, the entry written DEPTH samples earlier is read back and halved by an arithmetic right shift. The halved value is added to the new input, and the sum is saturated. The saturated sum becomes the audio output and is also written back into the delay line. Each pass through the loop therefore halves the echo, and the echoes die away geometrically.

Samples arrive with a one-cycle strobe at any rate up to one per clock. The result appears one clock later with its own valid flag. The delay, counted in samples, is set by the DEPTH parameter, which must be at least 2. After reset the delay line counts as empty until it has been filled once. The first DEPTH outputs therefore pass the input through unchanged.

Top module: `echo_feedback`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid is 0 and out_sample is 0.
- R2: out_valid is 1 in exactly the cycle after each cycle in which in_valid is 1, and 0 otherwise.
- R3: For the first DEPTH strobes after reset, out_sample equals the input sample of the same strobe, whatever the RAM holds.
- R4: From strobe DEPTH+1 on, out_sample = sat(in_sample + (y >>> 1)), where y is the output produced DEPTH strobes earlier.
- R5: The halving keeps the sign and rounds toward minus infinity: a stored -3 contributes -2, a stored -1 contributes -1, and a stored -32768 contributes -16384.
- R6: A sum above +32767 is output as +32767 (0x7FFF).
- R7: A sum below -32768 is output as -32768 (0x8000).
- R8: Cycles without a strobe do not advance the delay line, so the echo spacing counts strobes and not clocks.
- R9: out_sample holds its value in every cycle after which no strobe occurred.
- R10: Strobes on consecutive clocks are each processed correctly, including the wrap of the circular pointer from DEPTH-1 back to 0.
- R11: A reset in the middle of a stream discards all echo history, and R3 applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle strobe marking a new input sample |
| in_sample | input | 16 | Signed two's-complement input sample |
| out_valid | output | 1 | High for one cycle when out_sample carries a new result |
| out_sample | output | 16 | Signed two's-complement echo-mixed output |

## Verification
The bench builds the block with DEPTH = 5. This is not a power of two, so the pointer must wrap at DEPTH-1 itself rather than on address overflow. The short depth lets the bench reach the end of the pass-through phase and the first and second echo generations within a few dozen samples. Those generations include a negative odd value, positive and negative full-scale values, and both saturation directions. The stimulus mixes back-to-back strobes with idle gaps, which checks that the echo spacing counts strobes. A mid-stream reset then checks that history from before the reset never leaks out.

// File: rtl/echo_pkg.sv
package echo_pkg;

    localparam int SAMPLE_W = 16;

    typedef logic signed [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        logic    valid;
        sample_t data;
    } stream_t;

    localparam sample_t SAMPLE_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam sample_t SAMPLE_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

    // Divide by two with the sign bit copied into the vacated top position.
    function automatic sample_t halve_signed(input sample_t s);
        return {s[SAMPLE_W-1], s[SAMPLE_W-1:1]};
    endfunction

    // Add at one extra bit, then clamp to the representable range.
    function automatic sample_t add_clamped(input sample_t a, input sample_t b);
        logic signed [SAMPLE_W:0] wide;
        wide = {a[SAMPLE_W-1], a} + {b[SAMPLE_W-1], b};
        if (wide[SAMPLE_W] != wide[SAMPLE_W-1])
            return wide[SAMPLE_W] ? SAMPLE_MIN : SAMPLE_MAX;
        return wide[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/echo_ptr.sv
module echo_ptr #(
    parameter int DEPTH = 4096,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          primed
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_inc;

    assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    assign wr_addr = ptr_q;
    // Prefetch the entry the next strobe will need.
    assign rd_addr = step ? ptr_inc : ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            primed <= 1'b0;
        end else if (step) begin
            ptr_q <= ptr_inc;
            if (ptr_q == LAST)
                primed <= 1'b1;
        end
    end

    a_r10_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        step && (ptr_q == LAST) |=> ptr_q == '0);

    a_r8_idle_holds_ptr: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(ptr_q));

    a_r10_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= LAST);

endmodule

// File: rtl/echo_ram.sv
module echo_ram #(
    parameter int DEPTH = 4096,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [AW-1:0]         waddr,
    input  echo_pkg::sample_t     wdata,
    input  logic [AW-1:0]         raddr,
    output echo_pkg::sample_t     rdata
);
    echo_pkg::sample_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/echo_feedback.sv
module echo_feedback #(
    parameter int DEPTH = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [15:0] in_sample,
    output logic        out_valid,
    output logic [15:0] out_sample
);
    import echo_pkg::*;

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic          primed;
    sample_t       ram_q;
    sample_t       delayed;
    sample_t       fed_back;
    sample_t       mixed;
    stream_t       out_q;

    echo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .step    (in_valid),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .primed  (primed)
    );

    echo_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (in_valid),
        .waddr (wr_addr),
        .wdata (mixed),
        .raddr (rd_addr),
        .rdata (ram_q)
    );

    // Entries not yet written since reset read as silence.
    assign delayed  = primed ? ram_q : '0;
    assign fed_back = halve_signed(delayed);
    assign mixed    = add_clamped(sample_t'(in_sample), fed_back);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= in_valid;
            if (in_valid)
                out_q.data <= mixed;
        end
    end

    assign out_valid  = out_q.valid;
    assign out_sample = out_q.data;

    a_r2_valid_follows_strobe: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sample));

    a_r3_pass_through: assert property (@(posedge clk) disable iff (rst)
        in_valid && !primed |=> out_sample == $past(in_sample));

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_sample[15] && !fed_back[15] |=> !out_sample[15]);

    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_sample[15] && fed_back[15] |=> out_sample[15]);

    a_r5_sign_kept: assert property (@(posedge clk) disable iff (rst)
        primed && in_valid |-> fed_back[15] == ram_q[15]);

endmodule

// File: tb/echo_feedback_tb.sv
module echo_feedback_tb;

    localparam int DEPTH = 5;
    localparam int NV    = 15;

    // stimulus, expected output, idle cycles after the strobe
    localparam int VIN [NV] = '{1000, -1000, -3, 32767, -32768,
                                100, 0, 0, 20000, -20000,
                                7, 1, 0, 0, 0};
    localparam int VEXP[NV] = '{1000, -1000, -3, 32767, -32768,
                                600, -500, -2, 32767, -32768,
                                307, -249, -1, 16383, -16384};
    localparam int VGAP[NV] = '{0, 1, 0, 2, 0,
                                0, 3, 1, 0, 0,
                                2, 0, 1, 0, 0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        out_valid;
    logic [15:0] out_sample;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    echo_feedback #(.DEPTH(DEPTH)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    task automatic check(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe_and_check(input string req, input int value, input int exp);
        logic [15:0] e16;
        e16 = 16'(exp);
        in_valid  = 1'b1;
        in_sample = 16'(value);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, out_valid == 1'b1, int'(out_valid), 1);
        check(req, out_sample == e16, int'($signed(out_sample)), exp);
    endtask

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", out_valid == 1'b0, int'(out_valid), 0);
        check("R1", out_sample == 16'd0, int'($signed(out_sample)), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", out_valid == 1'b0, int'(out_valid), 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int k = 0; k < NV; k++) begin
            in_valid  = 1'b1;
            in_sample = 16'(VIN[k]);
            @(negedge clk);
            check(k < DEPTH ? "R3" : (k == 7 || k == 12) ? "R5" :
                  (k == 8) ? "R6" : (k == 9) ? "R7" : "R4",
                  out_sample == 16'(VEXP[k]), int'($signed(out_sample)), VEXP[k]);
            check("R2", out_valid == 1'b1, int'(out_valid), 1);
            held = out_sample;
            if (VGAP[k] > 0) begin
                in_valid = 1'b0;
                for (int g = 0; g < VGAP[k]; g++) begin
                    @(negedge clk);
                    check("R2", out_valid == 1'b0, int'(out_valid), 0);
                    check("R9", out_sample == held, int'($signed(out_sample)), int'($signed(held)));
                end
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R2", out_valid == 1'b0, int'(out_valid), 0);

        // R11: mid-stream reset, RAM still holds old echoes
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", out_sample == 16'd0, int'($signed(out_sample)), 0);
        check("R1", out_valid == 1'b0, int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        strobe_and_check("R11", 555, 555);
        for (int j = 0; j < DEPTH - 1; j++)
            strobe_and_check("R11", 0, 0);
        // R4 after refill: 10 + (555 >>> 1) = 287
        strobe_and_check("R4", 10, 287);
        // R8: idle cycles do not shift the echo; next echo of first zero is 0
        repeat (4) @(negedge clk);
        strobe_and_check("R8", -7, -7);
        // R5: most negative value halves to -16384
        for (int j = 0; j < DEPTH - 2; j++)
            strobe_and_check("R10", -32768, -32768);
        strobe_and_check("R5", 0, 143);
        strobe_and_check("R5", 0, -4);
        strobe_and_check("R5", 0, -16384);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule